// File: doc/BRIEF.md
# Dual-Sample Transient-Filtering Register

This register stage guards a word produced by combinational logic against short single-event glitches. When a capture strobe arrives, it samples the data word at once. It samples the same word again a fixed number of fast-clock cycles later. Each output bit is held by a C-element. The bit takes the sampled value only when both samples agree, and keeps its previous value when they differ. A glitch that covers only one of the two sampling instants is therefore masked in place rather than captured.

When any bit differs between the two samples, a one-cycle error flag is raised, so that upstream control can repeat the computation. The gap between the samples, `DELAY`, sets the widest transient that can be caught. It is also the added latency of each capture. A strobe that arrives while a capture is still in progress is dropped.

Top module: `dsf_register`

## Requirements
- R1: A low `rst_n` at a rising clock edge clears `q_o`, `err_o` and both internal samples, and abandons any capture in progress, so that no output update follows from it.
- R2: The first sample is taken at the edge where `cap_i` is accepted. The second sample is taken exactly `DELAY` edges later. Data values present at any other edge have no effect.
- R3: At the edge `DELAY`+1 edges after acceptance, every output bit whose two samples agree takes that sample value.
- R4: At that same edge, every output bit whose two samples differ keeps its previous value.
- R5: `err_o` is high for exactly one cycle, following the update edge, when at least one bit differs between the samples. It stays low when all bits agree.
- R6: `cap_i` is accepted only when no capture is in progress. A strobe seen from the accepting edge through the update edge is ignored.
- R7: `q_o` changes at no edge other than an update edge.
- R8: A transient lasting fewer than `DELAY` cycles that lies strictly between the two sampling edges leaves `err_o` low and produces the undisturbed value on `q_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cap_i | input | 1 | Capture strobe; starts a capture when idle |
| data_i | input | WIDTH | Word from the combinational logic |
| q_o | output | WIDTH | Filtered registered output |
| err_o | output | 1 | One-cycle flag for a sample mismatch |

## Verification
Two functions can coincide in one cycle: a C-element update and a new strobe. The update resolves the current capture, while the strobe could start the next one. Likewise, a strobe can coincide with the instant the second sample is taken.

The bench provokes these coincidences by holding `cap_i` high with foreign data throughout a capture. It then judges the outcome by the update edge and the output value. A wrongly accepted strobe shifts the update edge later and leaves the previous output visible where the new value is expected. A reset issued in the middle of a capture is also judged by the absence of any later update or flag.

// File: rtl/dsf_pkg.sv
// Package: shared types for the dual-sample filtering register.
// Assumes nothing beyond a single clock domain.
package dsf_pkg;

    // Phase of one capture: idle, waiting for the second sample, resolving.
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_WAIT    = 2'd1,
        PH_RESOLVE = 2'd2
    } dsf_phase_t;

endpackage

// File: rtl/dsf_sequencer.sv
// Module: dsf_sequencer
// Turns an accepted capture strobe into three timed pulses: first-sample
// enable at the accepting edge, second-sample enable DELAY edges later,
// and resolve one edge after that. Strobes are ignored while busy.
// Assumes 1 <= DELAY <= 15 and a synchronous active-low reset.
module dsf_sequencer
    import dsf_pkg::*;
#(
    parameter int DELAY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_i,
    output logic take_first_o,
    output logic take_second_o,
    output logic resolve_o,
    output logic busy_o
);

    localparam int CW = $clog2(DELAY + 1);
    localparam logic [CW-1:0] LOAD = CW'(DELAY);
    localparam logic [CW-1:0] LAST = CW'(1);

    dsf_phase_t     phase;
    logic [CW-1:0]  cnt;

    // Decode the pulses from the current phase and countdown.
    always_comb begin
        take_first_o  = (phase == PH_IDLE) && cap_i;
        take_second_o = (phase == PH_WAIT) && (cnt == LAST);
        resolve_o     = (phase == PH_RESOLVE);
        busy_o        = (phase != PH_IDLE);
    end

    // Phase register and countdown to the second sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (cap_i) begin
                        phase <= PH_WAIT;
                        cnt   <= LOAD;
                    end
                end
                PH_WAIT: begin
                    if (cnt == LAST) begin
                        phase <= PH_RESOLVE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_RESOLVE: phase <= PH_IDLE;
                default:    phase <= PH_IDLE;
            endcase
        end
    end

    // The countdown steps by one per edge while waiting (R2).
    p_countdown_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WAIT && cnt > LAST) |=> (phase == PH_WAIT && cnt == $past(cnt) - 1'b1));

    // The second sample is always followed by exactly one resolve (R3).
    p_second_then_resolve_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_second_o |=> (resolve_o ##1 !resolve_o));

    // A resolve returns the sequencer to idle (R6).
    p_resolve_to_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        resolve_o |=> (phase == PH_IDLE));

endmodule

// File: rtl/dsf_sample_pair.sv
// Module: dsf_sample_pair
// Holds the two time-shifted samples of the data word. Each register
// loads only on its own enable pulse from the sequencer.
// Assumes the two enables are never high in the same cycle.
module dsf_sample_pair #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_first_i,
    input  logic             take_second_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] early_o,
    output logic [WIDTH-1:0] late_o
);

    // Sample at the nominal instant.
    always_ff @(posedge clk) begin
        if (!rst_n)            early_o <= '0;
        else if (take_first_i) early_o <= data_i;
    end

    // Sample after the delay.
    always_ff @(posedge clk) begin
        if (!rst_n)             late_o <= '0;
        else if (take_second_i) late_o <= data_i;
    end

    // The two enables never coincide (R2).
    p_enables_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(take_first_i && take_second_i));

endmodule

// File: rtl/dsf_celement.sv
// Module: dsf_celement
// One clocked C-element bit. On enable, the output follows the two inputs
// when they agree and holds its previous value when they differ.
// Assumes the enable is a single-cycle pulse.
module dsf_celement (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic a_i,
    input  logic b_i,
    output logic q_o
);

    // Agreement updates the bit; disagreement keeps it.
    always_ff @(posedge clk) begin
        if (!rst_n)                    q_o <= 1'b0;
        else if (en_i && (a_i == b_i)) q_o <= a_i;
    end

    // Agreeing inputs are copied (R3).
    p_agree_copies_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && a_i == b_i) |=> (q_o == $past(a_i)));

    // Differing inputs leave the bit unchanged (R4).
    p_differ_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && a_i != b_i) |=> $stable(q_o));

endmodule

// File: rtl/dsf_mismatch.sv
// Module: dsf_mismatch
// Compares the two samples bit by bit and registers a one-cycle flag
// when any bit differs at resolve time.
// Assumes resolve pulses are separated by at least two cycles.
module dsf_mismatch #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [WIDTH-1:0] early_i,
    input  logic [WIDTH-1:0] late_i,
    output logic             err_o
);

    logic [WIDTH-1:0] diff;

    // Bitwise difference of the two samples.
    always_comb diff = early_i ^ late_i;

    // Flag register: set on a resolve with any difference, cleared otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) err_o <= 1'b0;
        else        err_o <= en_i && (|diff);
    end

endmodule

// File: rtl/dsf_register.sv
// Module: dsf_register (top)
// Transient-filtering register: two samples DELAY cycles apart, a C-element
// per output bit, and a one-cycle mismatch flag.
// Assumes 1 <= DELAY <= 15 and data driven from the clk domain.
module dsf_register
    import dsf_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DELAY = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] q_o,
    output logic             err_o
);

    logic             take_first;
    logic             take_second;
    logic             resolve;
    logic             busy;
    logic [WIDTH-1:0] early;
    logic [WIDTH-1:0] late;

    dsf_sequencer #(.DELAY(DELAY)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cap_i        (cap_i),
        .take_first_o (take_first),
        .take_second_o(take_second),
        .resolve_o    (resolve),
        .busy_o       (busy)
    );

    dsf_sample_pair #(.WIDTH(WIDTH)) u_samples (
        .clk          (clk),
        .rst_n        (rst_n),
        .take_first_i (take_first),
        .take_second_i(take_second),
        .data_i       (data_i),
        .early_o      (early),
        .late_o       (late)
    );

    // One C-element per output bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        dsf_celement u_cel (
            .clk  (clk),
            .rst_n(rst_n),
            .en_i (resolve),
            .a_i  (early[i]),
            .b_i  (late[i]),
            .q_o  (q_o[i])
        );
    end

    dsf_mismatch #(.WIDTH(WIDTH)) u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (resolve),
        .early_i(early),
        .late_i (late),
        .err_o  (err_o)
    );

    // Reset clears the visible state (R1).
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (q_o == '0 && !err_o));

    // The output moves only on a resolve edge (R7).
    p_output_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !resolve |=> $stable(q_o));

    // A strobe while busy leaves the first sample alone (R6).
    p_busy_ignores_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(early));

    // The error flag never lasts two cycles (R5).
    p_err_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    // The flag appears only right after a resolve (R5).
    p_err_after_resolve_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $past(resolve));

endmodule

// File: tb/tb_dsf_register.sv
module tb_dsf_register;

    localparam int W = 8;
    localparam int D = 3;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         cap;
    logic [W-1:0] data;
    logic [W-1:0] q;
    logic         err;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    dsf_register #(.WIDTH(W), .DELAY(D)) dut (
        .clk   (clk),
        .rst_n (rst_n),
        .cap_i (cap),
        .data_i(data),
        .q_o   (q),
        .err_o (err)
    );

    // Vectors: {first sample, glitch between, second sample, expected q, expected err}.
    // Expected q follows R3/R4 from the previous row; rows with a glitch test R2 and R8.
    localparam int NV = 8;
    localparam logic [39:0] VEC [NV] = '{
        {8'hA5, 8'h5A, 8'hA5, 8'hA5, 8'h00},
        {8'h3C, 8'h00, 8'h3C, 8'h3C, 8'h00},
        {8'hFF, 8'hFF, 8'h0F, 8'h3F, 8'h01},
        {8'h00, 8'hFF, 8'h00, 8'h00, 8'h00},
        {8'h81, 8'h81, 8'h80, 8'h80, 8'h01},
        {8'hFF, 8'h00, 8'hFF, 8'hFF, 8'h00},
        {8'h0F, 8'hAA, 8'hF0, 8'hFF, 8'h01},
        {8'h5A, 8'h5A, 8'h5A, 8'h5A, 8'h00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // One capture: first sample a, glitch g on the middle edges, second sample b.
    // poke keeps the strobe high during the wait to test R6.
    task automatic run_cap(input logic [W-1:0] a, input logic [W-1:0] g,
                           input logic [W-1:0] b, input bit poke,
                           input logic [W-1:0] exp_q, input logic exp_e,
                           input logic [W-1:0] prev_q);
        @(negedge clk); cap = 1'b1; data = a;
        @(posedge clk);
        for (int i = 1; i < D; i++) begin
            @(negedge clk); cap = poke; data = g;
            @(posedge clk);
        end
        @(negedge clk); cap = poke; data = b;
        @(posedge clk);
        @(negedge clk);
        chk("R7 hold before update", q, prev_q);
        data = ~b;
        @(posedge clk);
        @(negedge clk);
        chk("R3 R4 q after update", q, exp_q);
        chk("R5 err after update", err, exp_e);
        cap = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R5 err one cycle", err, 1'b0);
    endtask

    initial begin
        logic [W-1:0] prev;
        rst_n = 1'b0; cap = 1'b0; data = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 reset q", q, '0);
        chk("R1 reset err", err, 1'b0);
        rst_n = 1'b1;

        // Table walk: R2, R3, R4, R5, R8.
        prev = '0;
        for (int v = 0; v < NV; v++) begin
            run_cap(VEC[v][39:32], VEC[v][31:24], VEC[v][23:16], 1'b0,
                    VEC[v][15:8], VEC[v][0], prev);
            prev = VEC[v][15:8];
        end

        // R6: strobe held high with foreign data during the capture.
        run_cap(8'h11, 8'h77, 8'h11, 1'b1, 8'h11, 1'b0, prev);
        for (int i = 0; i < D + 3; i++) begin
            @(negedge clk);
            chk("R6 no stray flag", err, 1'b0);
        end
        chk("R6 q kept", q, 8'h11);

        // R1: reset in the middle of a capture abandons it.
        @(negedge clk); cap = 1'b1; data = 8'hFF;
        @(posedge clk);
        @(negedge clk); cap = 1'b0; rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 mid reset q", q, '0);
        chk("R1 mid reset err", err, 1'b0);
        rst_n = 1'b1; data = 8'h0F;
        for (int i = 0; i < D + 3; i++) begin
            @(negedge clk);
            chk("R1 no late update err", err, 1'b0);
        end
        chk("R1 no late update q", q, '0);

        // Capture works again after reset.
        run_cap(8'hC3, 8'h3C, 8'hC3, 1'b0, 8'hC3, 1'b0, 8'h00);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1..none act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule